// File: doc/BRIEF.md
# Hash-Based Queue and Profile Selector

This block receives one 64-bit hash per frame and turns it into two results: a 24-bit frame queue identifier and an 8-bit policer profile index. A configurable right shift selects a 24-bit window of the hash. That window is ANDed with a 24-bit mask and ORed into a queue base. The same masked window can be shifted again, masked with an 8-bit profile mask and added to a profile base. Each of the two outputs has its own bypass bit. When a bypass bit is set, that output is just its base value.

The configuration fields arrive on ports alongside the hash and are sampled in the same cycle as the hash. A field that breaks a limit makes the result invalid. Both outputs then fall back to their base values and an error flag travels with that result. Results leave through a single output register with a valid/ready handshake. A new hash is taken while the register is empty or being drained.

Top module: `hash_qsel`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.
- R2: For a valid configuration with queue bypass clear, out_qid = base[23:0] OR (((hash >> hash_shift)[23:0]) AND mask[23:0]).
- R3: For a valid configuration with profile bypass clear, out_pp = (pp_base + (((masked window >> pp_shift)[7:0]) AND pp_mask)) mod 256. The masked window is the 24-bit value ANDed in R2.
- R4: With cfg_qid_bypass = 1, out_qid equals base[23:0] whatever the hash is.
- R5: With cfg_pp_bypass = 1, out_pp equals cfg_pp_base whatever the hash is.
- R6: When either output uses the hash (at least one bypass clear), a hash shift above 40 is an error. A shift of 40 is legal.
- R7: When either output uses the hash, any set bit of cfg_hash_mask above bit 23 is an error.
- R8: Any set bit of cfg_base_qid above bit 23 is always an error.
- R9: With profile bypass clear, a profile shift above 23 is an error. A profile shift of 23 is legal.
- R10: out_err is 1 exactly for results whose configuration broke R6 to R9. An erroneous result carries out_qid = base[23:0] and out_pp = cfg_pp_base.
- R11: in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid = 1 and out_ready = 0, all outputs hold their values.
- R12: Each accepted hash produces exactly one result, one cycle after acceptance, and results come out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Hash and configuration are present |
| in_ready | output | 1 | Block takes the hash this cycle |
| in_hash | input | 64 | Hash result of the frame |
| cfg_hash_shift | input | 6 | Right shift applied to the hash |
| cfg_hash_mask | input | 32 | Window mask; only bits 23..0 may be set |
| cfg_base_qid | input | 32 | Queue base; only bits 23..0 may be set |
| cfg_qid_bypass | input | 1 | Queue identifier is the base only |
| cfg_pp_base | input | 8 | Profile base |
| cfg_pp_shift | input | 5 | Extra right shift for the profile |
| cfg_pp_mask | input | 8 | Profile mask |
| cfg_pp_bypass | input | 1 | Profile index is the base only |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_qid | output | 24 | Frame queue identifier |
| out_pp | output | 8 | Policer profile index |
| out_err | output | 1 | Configuration of this result was invalid |

## Verification
The hardest cases to reach are the error gates that depend on a bypass bit. An oversized hash shift or mask must be ignored only when both outputs are bypassed. An oversized profile shift must be ignored only when the profile is bypassed. Uniform random stimulus rarely lands on the exact limits of 40 and 23 together with the right bypass pair. So directed cases pin each limit and the value just above it under every bypass combination. Random traffic under random backpressure then covers the arithmetic and the stall behaviour.

// File: rtl/hqs_pkg.sv
// Package: default widths and limits shared by the selector modules.
// Assumes the queue window is never wider than the hash.
package hqs_pkg;
    localparam int HASH_W     = 64;
    localparam int QID_W      = 24;
    localparam int PP_W       = 8;
    localparam int CFG_W      = 32;
    localparam int SHIFT_W    = 6;
    localparam int PP_SHIFT_W = 5;

    // Largest hash shift that still leaves a full queue window.
    function automatic int max_hash_shift(input int hw, input int qw);
        return hw - qw;
    endfunction
endpackage

// File: rtl/hqs_cfg_check.sv
// Configuration checker: flags shift, mask and base fields that break
// their limits. Hash-side limits apply only when some output uses the hash.
// The profile shift limit applies only when the profile is not bypassed.
// Assumes CFG_W > QID_W.
module hqs_cfg_check #(
    parameter int QID_W      = 24,
    parameter int CFG_W      = 32,
    parameter int SHIFT_W    = 6,
    parameter int PP_SHIFT_W = 5,
    parameter int MAX_SHIFT  = 40
) (
    input  logic [SHIFT_W-1:0]    hash_shift,
    input  logic [CFG_W-1:0]      hash_mask,
    input  logic [CFG_W-1:0]      base_qid,
    input  logic                  qid_bypass,
    input  logic [PP_SHIFT_W-1:0] pp_shift,
    input  logic                  pp_bypass,
    output logic                  cfg_bad
);
    localparam int MAX_PP_SHIFT = QID_W - 1;

    logic uses_hash;
    logic shift_bad;
    logic mask_bad;
    logic base_bad;
    logic pp_bad;

    // Combine the individual limit checks into one error flag.
    always_comb begin
        uses_hash = !qid_bypass || !pp_bypass;
        shift_bad = int'(hash_shift) > MAX_SHIFT;
        mask_bad  = |hash_mask[CFG_W-1:QID_W];
        base_bad  = |base_qid[CFG_W-1:QID_W];
        pp_bad    = int'(pp_shift) > MAX_PP_SHIFT;
        cfg_bad   = base_bad
                  || (uses_hash && (shift_bad || mask_bad))
                  || (!pp_bypass && pp_bad);
    end
endmodule

// File: rtl/hqs_window.sv
// Window extractor: shifts the hash right and masks a QID_W-bit window.
// Assumes HASH_W >= QID_W.
module hqs_window #(
    parameter int HASH_W  = 64,
    parameter int QID_W   = 24,
    parameter int CFG_W   = 32,
    parameter int SHIFT_W = 6
) (
    input  logic [HASH_W-1:0]  hash,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CFG_W-1:0]   mask,
    output logic [QID_W-1:0]   window
);
    logic [HASH_W-1:0] shifted;

    // Shift the hash, then keep the masked low window.
    always_comb begin
        shifted = hash >> shift;
        window  = shifted[QID_W-1:0] & mask[QID_W-1:0];
    end
endmodule

// File: rtl/hqs_combine.sv
// Result combiner: forms the queue identifier and the profile index from
// the masked window. It applies the bypass bits and the error fallback.
// Assumes PP_W <= QID_W.
module hqs_combine #(
    parameter int QID_W      = 24,
    parameter int PP_W       = 8,
    parameter int CFG_W      = 32,
    parameter int PP_SHIFT_W = 5
) (
    input  logic [QID_W-1:0]      window,
    input  logic [CFG_W-1:0]      base_qid,
    input  logic                  qid_bypass,
    input  logic [PP_W-1:0]       pp_base,
    input  logic [PP_SHIFT_W-1:0] pp_shift,
    input  logic [PP_W-1:0]       pp_mask,
    input  logic                  pp_bypass,
    input  logic                  cfg_bad,
    output logic [QID_W-1:0]      qid,
    output logic [PP_W-1:0]       pp
);
    logic [QID_W-1:0] pp_src;
    logic [PP_W-1:0]  pp_part;

    // Queue identifier: base ORed with window unless bypassed or invalid.
    always_comb begin
        if (cfg_bad || qid_bypass) qid = base_qid[QID_W-1:0];
        else                       qid = base_qid[QID_W-1:0] | window;
    end

    // Profile index: base plus masked window slice, wrapping at PP_W bits.
    always_comb begin
        pp_src  = window >> pp_shift;
        pp_part = pp_src[PP_W-1:0] & pp_mask;
        if (cfg_bad || pp_bypass) pp = pp_base;
        else                      pp = pp_base + pp_part;
    end
endmodule

// File: rtl/hash_qsel.sv
// Hash-based queue and profile selector, top level.
// Samples hash and configuration together when in_valid && in_ready.
// It holds one result in an output register drained by out_ready.
// Assumes the configuration is stable only in the cycle it is sampled.
module hash_qsel #(
    parameter int HASH_W     = hqs_pkg::HASH_W,
    parameter int QID_W      = hqs_pkg::QID_W,
    parameter int PP_W       = hqs_pkg::PP_W,
    parameter int CFG_W      = hqs_pkg::CFG_W,
    parameter int SHIFT_W    = hqs_pkg::SHIFT_W,
    parameter int PP_SHIFT_W = hqs_pkg::PP_SHIFT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [HASH_W-1:0]     in_hash,
    input  logic [SHIFT_W-1:0]    cfg_hash_shift,
    input  logic [CFG_W-1:0]      cfg_hash_mask,
    input  logic [CFG_W-1:0]      cfg_base_qid,
    input  logic                  cfg_qid_bypass,
    input  logic [PP_W-1:0]       cfg_pp_base,
    input  logic [PP_SHIFT_W-1:0] cfg_pp_shift,
    input  logic [PP_W-1:0]       cfg_pp_mask,
    input  logic                  cfg_pp_bypass,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [QID_W-1:0]      out_qid,
    output logic [PP_W-1:0]       out_pp,
    output logic                  out_err
);
    localparam int MAX_SHIFT = hqs_pkg::max_hash_shift(HASH_W, QID_W);

    logic             cfg_bad;
    logic [QID_W-1:0] window;
    logic [QID_W-1:0] nxt_qid;
    logic [PP_W-1:0]  nxt_pp;
    logic             take;

    hqs_cfg_check #(
        .QID_W(QID_W), .CFG_W(CFG_W), .SHIFT_W(SHIFT_W),
        .PP_SHIFT_W(PP_SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
    ) u_check (
        .hash_shift(cfg_hash_shift), .hash_mask(cfg_hash_mask),
        .base_qid(cfg_base_qid), .qid_bypass(cfg_qid_bypass),
        .pp_shift(cfg_pp_shift), .pp_bypass(cfg_pp_bypass),
        .cfg_bad(cfg_bad)
    );

    hqs_window #(
        .HASH_W(HASH_W), .QID_W(QID_W), .CFG_W(CFG_W), .SHIFT_W(SHIFT_W)
    ) u_window (
        .hash(in_hash), .shift(cfg_hash_shift), .mask(cfg_hash_mask),
        .window(window)
    );

    hqs_combine #(
        .QID_W(QID_W), .PP_W(PP_W), .CFG_W(CFG_W), .PP_SHIFT_W(PP_SHIFT_W)
    ) u_combine (
        .window(window), .base_qid(cfg_base_qid), .qid_bypass(cfg_qid_bypass),
        .pp_base(cfg_pp_base), .pp_shift(cfg_pp_shift), .pp_mask(cfg_pp_mask),
        .pp_bypass(cfg_pp_bypass), .cfg_bad(cfg_bad),
        .qid(nxt_qid), .pp(nxt_pp)
    );

    // Accept when the output register is empty or being drained.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // Output register: load on accept, clear valid when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_qid   <= '0;
            out_pp    <= '0;
            out_err   <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_qid   <= nxt_qid;
            out_pp    <= nxt_pp;
            out_err   <= cfg_bad;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/hash_qsel_chk.sv
// Checker for hash_qsel: handshake, bypass and error properties.
module hash_qsel_chk #(
    parameter int QID_W = 24,
    parameter int PP_W  = 8,
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CFG_W-1:0] cfg_base_qid,
    input logic             cfg_qid_bypass,
    input logic [PP_W-1:0]  cfg_pp_base,
    input logic             cfg_pp_bypass,
    input logic             out_valid,
    input logic             out_ready,
    input logic [QID_W-1:0] out_qid,
    input logic [PP_W-1:0]  out_pp,
    input logic             out_err
);
    // R11: a stalled result keeps its value.
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_qid)
                                       && $stable(out_pp) && $stable(out_err)));

    // R11: no new hash while the held result is blocked.
    p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R12: an accepted hash yields a result in the next cycle.
    p_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8: an oversized queue base always flags an error.
    p_base_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (|cfg_base_qid[CFG_W-1:QID_W])) |=> out_err);

    // R4: queue bypass with a legal base yields the base.
    p_qid_byp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_qid_bypass && !(|cfg_base_qid[CFG_W-1:QID_W]))
        |=> out_qid == $past(cfg_base_qid[QID_W-1:0]));

    // R5: profile bypass yields the profile base.
    p_pp_byp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_pp_bypass) |=> out_pp == $past(cfg_pp_base));
endmodule

bind hash_qsel hash_qsel_chk #(.QID_W(QID_W), .PP_W(PP_W), .CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_base_qid(cfg_base_qid), .cfg_qid_bypass(cfg_qid_bypass),
    .cfg_pp_base(cfg_pp_base), .cfg_pp_bypass(cfg_pp_bypass),
    .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
    .out_pp(out_pp), .out_err(out_err)
);

// File: tb/hash_qsel_bench.sv
module hash_qsel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_hash = '0;
    logic [5:0]  cfg_hash_shift = '0;
    logic [31:0] cfg_hash_mask = '0;
    logic [31:0] cfg_base_qid = '0;
    logic        cfg_qid_bypass = 1'b0;
    logic [7:0]  cfg_pp_base = '0;
    logic [4:0]  cfg_pp_shift = '0;
    logic [7:0]  cfg_pp_mask = '0;
    logic        cfg_pp_bypass = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_qid;
    logic [7:0]  out_pp;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    int ready_pct = 75;

    typedef struct packed {
        logic [23:0] q;
        logic [7:0]  p;
        logic        e;
        logic [3:0]  qtag;
        logic [3:0]  ptag;
    } exp_t;
    exp_t exp_q[$];

    logic        held_v = 1'b0;
    logic [23:0] held_q;
    logic [7:0]  held_p;
    logic        held_e;

    always #5 clk = ~clk;

    hash_qsel u_hash_qsel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hash(in_hash), .cfg_hash_shift(cfg_hash_shift),
        .cfg_hash_mask(cfg_hash_mask), .cfg_base_qid(cfg_base_qid),
        .cfg_qid_bypass(cfg_qid_bypass), .cfg_pp_base(cfg_pp_base),
        .cfg_pp_shift(cfg_pp_shift), .cfg_pp_mask(cfg_pp_mask),
        .cfg_pp_bypass(cfg_pp_bypass), .out_valid(out_valid),
        .out_ready(out_ready), .out_qid(out_qid), .out_pp(out_pp),
        .out_err(out_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference model built from R2..R10.
    function automatic exp_t model();
        exp_t r;
        logic [63:0] sh;
        logic [23:0] win;
        logic [23:0] ps;
        logic uses, bad;
        int cause;
        uses = !cfg_qid_bypass || !cfg_pp_bypass;
        cause = 0;
        if (cfg_base_qid[31:24] != 0) cause = 8;                              // R8
        else if (uses && cfg_hash_shift > 40) cause = 6;                      // R6
        else if (uses && cfg_hash_mask[31:24] != 0) cause = 7;                // R7
        else if (!cfg_pp_bypass && cfg_pp_shift > 23) cause = 9;              // R9
        bad = cause != 0;
        sh  = in_hash >> cfg_hash_shift;
        win = sh[23:0] & cfg_hash_mask[23:0];
        ps  = win >> cfg_pp_shift;
        r.e = bad;
        if (bad) begin
            r.q = cfg_base_qid[23:0]; r.p = cfg_pp_base;
            r.qtag = 4'(cause); r.ptag = 4'(cause);
        end else begin
            r.q = cfg_qid_bypass ? cfg_base_qid[23:0] : (cfg_base_qid[23:0] | win);
            r.qtag = cfg_qid_bypass ? 4'd4 : 4'd2;                            // R4 / R2
            r.p = cfg_pp_bypass ? cfg_pp_base : 8'(cfg_pp_base + (ps[7:0] & cfg_pp_mask));
            r.ptag = cfg_pp_bypass ? 4'd5 : 4'd3;                             // R5 / R3
        end
        return r;
    endfunction

    // Output-side checks, run 1 time unit after the falling edge.
    task automatic observe();
        exp_t e;
        check(in_ready == (!out_valid || out_ready), "R11 in_ready",
              32'(in_ready), 32'(!out_valid || out_ready));
        if (held_v) begin
            check(out_valid && out_qid == held_q && out_pp == held_p && out_err == held_e,
                  "R11 stall hold", {out_qid, out_pp}, {held_q, held_p});
        end
        held_v = out_valid && !out_ready;
        held_q = out_qid; held_p = out_pp; held_e = out_err;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 extra result", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(out_qid == e.q, $sformatf("R%0d qid", e.qtag), 32'(out_qid), 32'(e.q));
                check(out_pp == e.p, $sformatf("R%0d pp", e.ptag), 32'(out_pp), 32'(e.p));
                check(out_err == e.e, "R10 err", 32'(out_err), 32'(e.e));
            end
        end
    endtask

    task automatic step(input bit give);
        bit done;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            in_valid  = give;
            out_ready = ($urandom % 100) < ready_pct;
            #1;
            observe();
            if (!give) done = 1'b1;
            else if (in_ready) begin
                exp_q.push_back(model());
                done = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        observe();
    endtask

    task automatic setcfg(input logic [63:0] h, input logic [5:0] s, input logic [31:0] m,
                          input logic [31:0] b, input bit qb, input logic [7:0] pb,
                          input logic [4:0] psh, input logic [7:0] pm, input bit pbyp);
        in_hash = h; cfg_hash_shift = s; cfg_hash_mask = m; cfg_base_qid = b;
        cfg_qid_bypass = qb; cfg_pp_base = pb; cfg_pp_shift = psh;
        cfg_pp_mask = pm; cfg_pp_bypass = pbyp;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle state",
              {out_valid, in_ready}, 32'b01);

        // Directed: limit values and the values just above them (R6, R9).
        for (int qb = 0; qb < 2; qb++) begin
            for (int pb = 0; pb < 2; pb++) begin
                setcfg(64'hFFFF_FFFF_FFFF_FFFF, 6'd40, 32'h00FF_FFFF, 32'h0012_0000,
                       qb[0], 8'hF0, 5'd23, 8'hFF, pb[0]); step(1);
                setcfg(64'hFFFF_FFFF_FFFF_FFFF, 6'd41, 32'h00FF_FFFF, 32'h0012_0000,
                       qb[0], 8'hF0, 5'd0, 8'hFF, pb[0]); step(1);
                setcfg(64'h0123_4567_89AB_CDEF, 6'd8, 32'h00FF_FFFF, 32'h0000_0100,
                       qb[0], 8'h10, 5'd24, 8'h0F, pb[0]); step(1);
                setcfg(64'h0123_4567_89AB_CDEF, 6'd0, 32'h0100_0000, 32'h0000_0000,
                       qb[0], 8'h22, 5'd3, 8'h3F, pb[0]); step(1);
                setcfg(64'h0123_4567_89AB_CDEF, 6'd4, 32'h00FF_0000, 32'h8000_0000,
                       qb[0], 8'h33, 5'd1, 8'hFF, pb[0]); step(1);
            end
        end
        // Directed: profile sum wraps at 8 bits (R3).
        setcfg(64'h0000_0000_00FF_FFFF, 6'd0, 32'h00FF_FFFF, 32'h0, 1'b0,
               8'hFF, 5'd0, 8'hFF, 1'b0); step(1);

        // Random traffic with random backpressure (R2..R12).
        for (int i = 0; i < 1500; i++) begin
            ready_pct = (i % 300 < 150) ? 90 : 40;
            setcfg({$urandom, $urandom}, 6'($urandom % 44),
                   ($urandom % 8 == 0) ? $urandom : ($urandom & 32'h00FF_FFFF),
                   ($urandom % 8 == 0) ? $urandom : ($urandom & 32'h00FF_FFFF),
                   ($urandom % 4 == 0), 8'($urandom), 5'($urandom % 26),
                   8'($urandom), ($urandom % 4 == 0));
            step(($urandom % 5) != 0);
        end

        // Drain and confirm every accepted hash produced one result (R12).
        ready_pct = 100;
        repeat (4) step(0);
        check(exp_q.size() == 0, "R12 results outstanding", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule